// File: doc/BRIEF.md
# Byte-Lane Strobe Generator

This block is the strobe stage of an external memory bank controller. It drives four active-low byte-lane strobes on a big-endian 32-bit data bus. Lane 0 carries the most significant byte (D0–D7). Lane 1 carries D8–D15, lane 2 carries D16–D23 and lane 3 carries D24–D31.

The lanes to assert depend on three things taken together: the bank's port-size code, the transfer-size code and the two low address bits. A per-bank mode bit sets what the strobes mean. With the bit set they are byte enables and fire on both reads and writes. With the bit clear they are write enables and stay quiet on reads. The timing is the same in either mode.

The controller raises a cycle-active strobe for each bus cycle. On the first clock edge that sees it high, the block registers the lane pattern. It holds that pattern until the edge that sees the strobe low again. A reserved port code, or a half-word at an odd address, releases every lane and pulses an error flag.

Top module: `lane_strobe_gen`

## Requirements
- R1: While `rst` is sampled high, and on the cycle after it, `lane_n` is 4'b1111 and `err` is 0.
- R2: With port code 2'b00 (32-bit) and transfer code 2'b01 (byte), exactly one lane k is driven low, where k = `addr_lo`. Lane k appears on `lane_n[k]`, and lane 0 is data bits D0–D7.
- R3: With port code 2'b00, transfer code 2'b10 (half-word) drives lanes 0 and 1 low at offset 2'b00 and lanes 2 and 3 low at offset 2'b10. Transfer code 2'b00 (word) drives all four lanes low at any offset.
- R4: With port code 2'b10 (16-bit), a byte drives lane 0 low when `addr_lo[0]`=0 and lane 1 low when `addr_lo[0]`=1. A half-word or word drives lanes 0 and 1 low. Lanes 2 and 3 stay high.
- R5: With port code 2'b01 (8-bit), every transfer size and offset drives only lane 0 low.
- R6: With `be_mode`=0, a cycle with `is_write`=0 leaves `lane_n` at 4'b1111. A cycle with `is_write`=1 drives the lanes of R2–R5.
- R7: With `be_mode`=1, reads and writes drive the same lanes (R2–R5), in the same cycles.
- R8: `lane_n` is loaded on the first rising edge where `cyc_act` is sampled 1 after being 0. It then holds unchanged while `cyc_act` stays 1, even if the other inputs change. It returns to 4'b1111 on the first edge where `cyc_act` is sampled 0.
- R9: Port code 2'b11, or transfer code 2'b10 with `addr_lo[0]`=1, loads 4'b1111 at the cycle start. It also raises `err` for exactly one cycle, alongside that load. At all other times `err` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cyc_act | input | 1 | High for the duration of a bus cycle |
| port_sz | input | 2 | Bank port size: 00 32-bit, 10 16-bit, 01 8-bit, 11 reserved |
| xfer_sz | input | 2 | Transfer size: 01 byte, 10 half-word, 00 word |
| addr_lo | input | 2 | Two least significant address bits |
| is_write | input | 1 | 1 for a write cycle, 0 for a read |
| be_mode | input | 1 | 1 byte-enable meaning, 0 write-enable meaning |
| lane_n | output | 4 | Active-low byte-lane strobes, bit k is lane k |
| err | output | 1 | One-cycle pulse for an illegal cycle setup |

## Verification
The embedded properties assume that transfer code 2'b11 is never present on the edge that starts a cycle. The block gives that code no lane pattern, so the one-lane count for bytes and the lane counts per port would not hold for it. They also assume that `cyc_act` falls for at least one cycle between bus cycles, so that every cycle produces a start edge. The stimulus stays within these limits. It sweeps only the three defined transfer codes, and it always leaves an idle cycle between bus cycles. While a cycle is active, it changes every other input to show that the pattern is held.

// File: rtl/lane_strobe_pkg.sv
package lane_strobe_pkg;

  typedef enum logic [1:0] {
    PS_W32 = 2'b00,
    PS_W8  = 2'b01,
    PS_W16 = 2'b10,
    PS_RSV = 2'b11
  } port_sz_e;

  typedef enum logic [1:0] {
    XS_WORD = 2'b00,
    XS_BYTE = 2'b01,
    XS_HALF = 2'b10,
    XS_RSV  = 2'b11
  } xfer_sz_e;

endpackage

// File: rtl/lsg_lane_decode.sv
module lsg_lane_decode
  import lane_strobe_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int LANE_AW   = 2
) (
  input  logic [1:0]           port_sz,
  input  logic [1:0]           xfer_sz,
  input  logic [LANE_AW-1:0]   addr_lo,
  input  logic                 is_write,
  input  logic                 be_mode,
  output logic [NUM_LANES-1:0] lane_en,
  output logic                 bad
);

  port_sz_e             ps;
  xfer_sz_e             xs;
  logic [NUM_LANES-1:0] hit;
  logic                 qual;

  assign ps   = port_sz_e'(port_sz);
  assign xs   = xfer_sz_e'(xfer_sz);
  assign qual = be_mode | is_write;

  // illegal setup: reserved port code or half-word on an odd byte
  always_comb bad = (ps == PS_RSV) || ((xs == XS_HALF) && addr_lo[0]);

  generate
    for (genvar i = 0; i < NUM_LANES; i++) begin : g_lane
      localparam logic [LANE_AW-1:0] IDX = LANE_AW'(i);
      logic lh;
      always_comb begin
        lh = 1'b0;
        case (ps)
          PS_W32: begin
            case (xs)
              XS_BYTE: lh = (addr_lo == IDX);
              XS_HALF: lh = (addr_lo[1] == IDX[1]);
              XS_WORD: lh = 1'b1;
              default: lh = 1'b0;
            endcase
          end
          PS_W16: begin
            if (xs == XS_BYTE) lh = !IDX[1] && (addr_lo[0] == IDX[0]);
            else               lh = !IDX[1] && (xs != XS_RSV);
          end
          PS_W8:   lh = (IDX == '0) && (xs != XS_RSV);
          default: lh = 1'b0;
        endcase
      end
      assign hit[i] = lh;
    end
  endgenerate

  always_comb lane_en = (qual && !bad) ? hit : '0;

endmodule

// File: rtl/lsg_strobe_window.sv
module lsg_strobe_window #(
  parameter int NUM_LANES = 4
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start,
  input  logic                 cyc_act,
  input  logic [NUM_LANES-1:0] lane_en,
  input  logic                 bad,
  output logic [NUM_LANES-1:0] lane_n,
  output logic                 err
);

  always_ff @(posedge clk) begin
    if (rst) begin
      lane_n <= '1;
      err    <= 1'b0;
    end else begin
      err <= start & bad;
      if (start)         lane_n <= ~lane_en;
      else if (!cyc_act) lane_n <= '1;
    end
  end

  // R8: idle cycles release every lane
  assert_idle_high_R8: assert property (@(posedge clk) disable iff (rst)
    !cyc_act |=> (&lane_n));

  // R8: pattern frozen for the rest of an active cycle
  assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (cyc_act && !start) |=> $stable(lane_n));

  // R9: error lasts a single cycle
  assert_err_pulse_R9: assert property (@(posedge clk) disable iff (rst)
    err |=> !err);

  // R9: no lane driven while flagging an error
  assert_err_blank_R9: assert property (@(posedge clk) disable iff (rst)
    err |-> (&lane_n));

endmodule

// File: rtl/lane_strobe_gen.sv
module lane_strobe_gen
  import lane_strobe_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          cyc_act,
  input  logic [1:0]                    port_sz,
  input  logic [1:0]                    xfer_sz,
  input  logic [$clog2(DATA_W/8)-1:0]   addr_lo,
  input  logic                          is_write,
  input  logic                          be_mode,
  output logic [DATA_W/8-1:0]           lane_n,
  output logic                          err
);

  localparam int NUM_LANES = DATA_W / 8;
  localparam int LANE_AW   = $clog2(NUM_LANES);
  localparam int HALF_L    = NUM_LANES / 2;

  logic                 act_q;
  logic                 start;
  logic [NUM_LANES-1:0] lane_en;
  logic                 bad;

  always_ff @(posedge clk) begin
    if (rst) act_q <= 1'b0;
    else     act_q <= cyc_act;
  end

  assign start = cyc_act & ~act_q;

  lsg_lane_decode #(.NUM_LANES(NUM_LANES), .LANE_AW(LANE_AW)) u_decode (
    .port_sz (port_sz),
    .xfer_sz (xfer_sz),
    .addr_lo (addr_lo),
    .is_write(is_write),
    .be_mode (be_mode),
    .lane_en (lane_en),
    .bad     (bad)
  );

  lsg_strobe_window #(.NUM_LANES(NUM_LANES)) u_window (
    .clk    (clk),
    .rst    (rst),
    .start  (start),
    .cyc_act(cyc_act),
    .lane_en(lane_en),
    .bad    (bad),
    .lane_n (lane_n),
    .err    (err)
  );

  // R6: write-enable meaning ignores reads
  assert_read_quiet_R6: assert property (@(posedge clk) disable iff (rst)
    (start && !be_mode && !is_write) |=> (&lane_n));

  // R2: a qualified byte on a 32-bit port touches one lane
  assert_byte_one_R2: assert property (@(posedge clk) disable iff (rst)
    (start && xfer_sz == XS_BYTE && port_sz == PS_W32 && (be_mode || is_write))
      |=> ($countones(~lane_n) == 1));

  // R5: 8-bit port never touches lanes above 0
  assert_narrow_R5: assert property (@(posedge clk) disable iff (rst)
    (start && port_sz == PS_W8) |=> (&lane_n[NUM_LANES-1:1]));

  // R4: 16-bit port never touches the low-order half of the bus
  assert_port16_R4: assert property (@(posedge clk) disable iff (rst)
    (start && port_sz == PS_W16) |=> (&lane_n[NUM_LANES-1:HALF_L]));

endmodule

// File: tb/tb_lane_strobe_gen.sv
`timescale 1ns/1ps
module tb_lane_strobe_gen;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cyc_act = 1'b0;
  logic [1:0] port_sz = 2'b00;
  logic [1:0] xfer_sz = 2'b00;
  logic [1:0] addr_lo = 2'b00;
  logic       is_write = 1'b0;
  logic       be_mode = 1'b0;
  logic [3:0] lane_n;
  logic       err;

  int    n_checks = 0;
  int    n_fail   = 0;
  string cur_req  = "R1";
  bit    model_on = 1'b0;

  always #4 clk = ~clk;

  lane_strobe_gen dut (
    .clk(clk), .rst(rst), .cyc_act(cyc_act), .port_sz(port_sz),
    .xfer_sz(xfer_sz), .addr_lo(addr_lo), .is_write(is_write),
    .be_mode(be_mode), .lane_n(lane_n), .err(err)
  );

  // behavioural expectation: lanes = bytes covered by the transfer within the port
  function automatic logic [3:0] ref_lanes(int p, int x, int a, bit wr, bit md,
                                           output bit is_bad);
    int width, size, eff, first;
    logic [3:0] r;
    width  = (p == 0) ? 4 : (p == 2) ? 2 : 1;
    size   = (x == 1) ? 1 : (x == 2) ? 2 : 4;
    is_bad = (p == 3) || (x == 2 && (a % 2) == 1);
    r = 4'hF;
    if (!is_bad && (md || wr)) begin
      eff   = (size < width) ? size : width;
      first = ((a % width) / eff) * eff;
      for (int k = first; k < first + eff; k++) r[k] = 1'b0;
    end
    return r;
  endfunction

  logic [3:0] m_lane_n;
  logic       m_err;
  logic       m_act;

  always @(posedge clk) begin : model
    bit         b_v;
    logic [3:0] l_v;
    if (rst) begin
      m_lane_n <= 4'hF; m_err <= 1'b0; m_act <= 1'b0;
    end else begin
      m_act <= cyc_act;
      m_err <= 1'b0;
      if (cyc_act && !m_act) begin
        l_v = ref_lanes(port_sz, xfer_sz, addr_lo, is_write, be_mode, b_v);
        m_lane_n <= l_v;
        m_err    <= b_v;
      end else if (!cyc_act) begin
        m_lane_n <= 4'hF;
      end
    end
    model_on <= 1'b1;
  end

  task automatic chk(string req, string what, logic [3:0] got, logic [3:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b at %0t", req, what, got, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (model_on) begin
      chk(cur_req, "lane_n vs model", lane_n, m_lane_n);
      chk(cur_req, "err vs model", {3'b0, err}, {3'b0, m_err});
    end
  end

  function automatic string tag_for(int p, int x, int a, bit wr, bit md);
    if (p == 3 || (x == 2 && a % 2 == 1)) return "R9";
    if (!md && !wr) return "R6";
    if (md && !wr)  return "R7";
    if (p == 1) return "R5";
    if (p == 2) return "R4";
    if (x == 1) return "R2";
    return "R3";
  endfunction

  task automatic begin_cyc(int p, int x, int a, bit wr, bit md);
    @(negedge clk);
    port_sz = 2'(p); xfer_sz = 2'(x); addr_lo = 2'(a);
    is_write = wr; be_mode = md; cyc_act = 1'b1;
    cur_req = tag_for(p, x, a, wr, md);
    @(negedge clk);
  endtask

  task automatic end_cyc();
    cyc_act = 1'b0;
    @(negedge clk);
  endtask

  initial begin : stim
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1", "lane_n in reset", lane_n, 4'hF);
    chk("R1", "err in reset", {3'b0, err}, 4'h0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "lane_n after reset", lane_n, 4'hF);

    begin_cyc(0, 1, 3, 1, 0);
    chk("R2", "32-bit byte offset 3", lane_n, 4'b0111);
    addr_lo = 2'b00; port_sz = 2'b01; xfer_sz = 2'b00; is_write = 1'b0;
    cur_req = "R8";
    @(negedge clk);
    chk("R8", "held while active", lane_n, 4'b0111);
    end_cyc();
    chk("R8", "released after active", lane_n, 4'hF);

    begin_cyc(0, 2, 2, 0, 1);
    chk("R3", "32-bit half offset 2 read", lane_n, 4'b0011);
    end_cyc();
    begin_cyc(2, 1, 1, 1, 0);
    chk("R4", "16-bit byte odd", lane_n, 4'b1101);
    end_cyc();
    begin_cyc(1, 0, 2, 1, 0);
    chk("R5", "8-bit word", lane_n, 4'b1110);
    end_cyc();
    begin_cyc(0, 0, 0, 0, 0);
    chk("R6", "read in write-enable mode", lane_n, 4'hF);
    end_cyc();
    begin_cyc(0, 0, 0, 0, 1);
    chk("R7", "read in byte-enable mode", lane_n, 4'b0000);
    end_cyc();
    begin_cyc(0, 2, 1, 1, 1);
    chk("R9", "misaligned half lanes", lane_n, 4'hF);
    chk("R9", "misaligned half err", {3'b0, err}, 4'h1);
    @(negedge clk);
    chk("R9", "err single cycle", {3'b0, err}, 4'h0);
    end_cyc();
    begin_cyc(3, 1, 0, 1, 1);
    chk("R9", "reserved port err", {3'b0, err}, 4'h1);
    end_cyc();

    for (int p = 0; p < 4; p++)
      for (int x = 0; x < 3; x++)
        for (int a = 0; a < 4; a++)
          for (int w = 0; w < 2; w++)
            for (int m = 0; m < 2; m++) begin
              begin_cyc(p, x, a, w[0], m[0]);
              for (int h = 0; h <= (a % 2); h++) begin
                addr_lo = ~addr_lo; be_mode = ~be_mode;
                is_write = ~is_write; xfer_sz = 2'(h);
                @(negedge clk);
              end
              end_cyc();
            end

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL R8 watchdog actual=hung expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule